// File: doc/BRIEF.md
# SMBus Alert Response Responder

A slave that has a fault to report pulls a shared open-drain alert line low. The bus master then reads from the broadcast alert response address. This block is the responder on the slave side. It keeps its alert pull-down enabled while a fault is pending. It watches the oversampled SCL and SDA lines for the broadcast read. When a fault is pending it acknowledges that read and sends its own 7-bit address in the next byte.

Other alerting slaves may answer the same broadcast. For that reason every bit the block releases is read back from the bus. If a released bit reads back as low, the block has lost arbitration. It then stops driving for the rest of the byte and keeps its alert asserted, so that a later broadcast can serve it. A responder that sends its whole address byte has won, and its pending flag is cleared. A fault that arrives while the response is in progress re-arms the flag, so that fault is not lost.

The block is clocked by the system clock. SCL and SDA reach it already synchronized. A fault is reported as a one-cycle pulse.

Top module: `alert_resp`

## Requirements
- R1: After reset, alert_oe and sda_oe are both 0 (both lines released).
- R2: A fault_i pulse sets alert_oe to 1 on the next clock, and alert_oe stays 1 until the block wins an alert response.
- R3: The bus is sampled on SCL rising edges, MSB first. A first byte equal to 0x19 (7-bit address 0001100 followed by read bit 1) while a fault is pending is acknowledged by holding SDA low for the ninth SCL clock.
- R4: With no fault pending, or with any other first byte (including the write form 0x18), the block leaves SDA released for the whole transaction. sda_oe is never 1 while alert_oe is 0.
- R5: The byte after the acknowledge carries OWN_ADDR in bits 7 to 1, MSB first, and bit 0 is 1 (released).
- R6: If a bit the block releases is sampled low on the SCL rising edge, the block releases SDA for the rest of the byte and alert_oe stays 1.
- R7: After the eighth data bit is sent without losing arbitration, alert_oe falls on the next clock. alert_oe never falls in any other way.
- R8: A fault_i pulse that arrives between the acknowledge and the end of a won byte leaves alert_oe at 1 after that byte.
- R9: A START (SDA falling with SCL high), a repeated START or a STOP (SDA rising with SCL high) returns the block to address reception from any state. It releases SDA and leaves the pending flag unchanged.
- R10: sda_oe changes only on the clock after SCL has been sampled low. A new bit therefore appears within two system clocks of SCL falling.
- R11: With two responders answering the same broadcast, the one with the lower address wins. The loser's alert stays asserted until a second broadcast serves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (wired-AND bus value) |
| fault_i | input | 1 | One-cycle fault event pulse |
| sda_oe | output | 1 | Enables the SDA pull-down |
| alert_oe | output | 1 | Enables the alert pull-down |

## Verification
The assertions assume the following about the inputs:
- SCL and SDA are already synchronous to clk.
- Each SCL phase lasts at least two system clocks.
- SDA moves only while SCL is low, except for START and STOP.

The bench master holds each SCL phase for four clocks and changes SDA only in the low phase. Around the bus it drives exactly one wired-AND of the master and the two responders. Fault pulses are one clock long, and one of them is placed inside a data byte on purpose.

// File: rtl/alert_resp_pkg.sv
package alert_resp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_PEND, ST_ACK, ST_TX
  } state_t;

  // first byte that asks alerting slaves to identify themselves
  function automatic logic is_ara(input logic [BYTE_W-1:0] b);
    return b == {ARA_ADDR, 1'b1};
  endfunction

  // byte sent back: own address in the upper bits, low bit released
  function automatic logic [BYTE_W-1:0] resp_byte(input logic [ADDR_W-1:0] a);
    return {a, 1'b1};
  endfunction
endpackage

// File: rtl/alert_resp_edges.sv
module alert_resp_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_evt = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_evt  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/alert_resp_pend.sv
module alert_resp_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic busy,
  input  logic clr,
  output logic pending
);
  logic rearm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      rearm   <= 1'b0;
    end else begin
      if (clr)          pending <= rearm | fault_i;
      else if (fault_i) pending <= 1'b1;
      rearm <= busy & (rearm | fault_i);
    end
  end
endmodule

// File: rtl/alert_resp_fsm.sv
module alert_resp_fsm
  import alert_resp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h2A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_i,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic pending,
  output logic drv_low,
  output logic busy,
  output logic arb_lost,
  output logic won_evt
);
  localparam logic [BYTE_W-1:0] RESP = resp_byte(OWN_ADDR);
  localparam logic [CNT_W-1:0]  LAST = CNT_W'(BYTE_W - 1);

  state_t            st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] rx_byte;

  assign rx_byte  = {sh[BYTE_W-2:0], sda_i};
  assign busy     = (st == ST_ACK_PEND) || (st == ST_ACK) || (st == ST_TX);
  assign arb_lost = (st == ST_TX) && scl_rise && !drv_low && !sda_i;
  assign won_evt  = (st == ST_TX) && scl_rise && (cnt == LAST) && !arb_lost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      drv_low <= 1'b0;
    end else if (start_evt) begin
      st      <= ST_ADDR;
      cnt     <= '0;
      drv_low <= 1'b0;
    end else if (stop_evt) begin
      st      <= ST_IDLE;
      drv_low <= 1'b0;
    end else begin
      case (st)
        ST_ADDR: if (scl_rise) begin
          sh  <= rx_byte;
          cnt <= cnt + CNT_W'(1);
          if (cnt == LAST)
            st <= (is_ara(rx_byte) && pending) ? ST_ACK_PEND : ST_IDLE;
        end
        ST_ACK_PEND: if (scl_fall) begin
          st      <= ST_ACK;
          drv_low <= 1'b1;
        end
        ST_ACK: if (scl_fall) begin
          st      <= ST_TX;
          sh      <= RESP;
          cnt     <= '0;
          drv_low <= ~RESP[BYTE_W-1];
        end
        ST_TX: if (scl_rise) begin
          cnt <= cnt + CNT_W'(1);
          if (arb_lost || cnt == LAST) begin
            st      <= ST_IDLE;
            drv_low <= 1'b0;
          end
        end else if (scl_fall) begin
          sh      <= {sh[BYTE_W-2:0], 1'b0};
          drv_low <= ~sh[BYTE_W-2];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/alert_resp.sv
module alert_resp
  import alert_resp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h2A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic fault_i,
  output logic sda_oe,
  output logic alert_oe
);
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic pending, busy, arb_lost, won_evt, drv_low;

  alert_resp_edges u_edges (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  alert_resp_pend u_pend (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i),
    .busy(busy), .clr(won_evt), .pending(pending)
  );

  alert_resp_fsm #(.OWN_ADDR(OWN_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .pending(pending), .drv_low(drv_low), .busy(busy),
    .arb_lost(arb_lost), .won_evt(won_evt)
  );

  assign sda_oe   = drv_low;
  assign alert_oe = pending;
endmodule

// File: rtl/alert_resp_chk.sv
module alert_resp_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic fault_i,
  input logic sda_oe,
  input logic alert_oe,
  input logic start_evt,
  input logic stop_evt,
  input logic arb_lost,
  input logic won_evt
);
  a_r2_fault_sets_alert: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> alert_oe);

  a_r4_no_drive_without_alert: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> alert_oe);

  a_r6_loser_releases: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> (!sda_oe && alert_oe));

  a_r7_alert_falls_only_on_win: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_oe) |-> $past(won_evt));

  a_r8_late_fault_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (won_evt && fault_i) |=> alert_oe);

  a_r9_bus_event_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_evt || stop_evt) && !fault_i) |=> (!sda_oe && alert_oe == $past(alert_oe)));

  a_r10_sda_moves_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_i));
endmodule

bind alert_resp alert_resp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .fault_i(fault_i),
  .sda_oe(sda_oe), .alert_oe(alert_oe), .start_evt(start_evt),
  .stop_evt(stop_evt), .arb_lost(arb_lost), .won_evt(won_evt)
);

// File: tb/sim_alert_resp.sv
module sim_alert_resp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic fault0 = 1'b0, fault1 = 1'b0;
  logic oe0, oe1, alert0, alert1;
  logic sda_bus;
  logic rd_strobe = 1'b0;
  logic [7:0] rd_byte = 8'h00;
  logic done = 1'b0;
  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~oe0 & ~oe1;

  alert_resp #(.OWN_ADDR(7'h2A)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .fault_i(fault0), .sda_oe(oe0), .alert_oe(alert0));
  alert_resp #(.OWN_ADDR(7'h4C)) u1 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .fault_i(fault1), .sda_oe(oe1), .alert_oe(alert1));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic hw(); repeat (4) @(negedge clk); endtask

  task automatic m_start();
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic m_wbit(input logic b);
    sda_m = b; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0; hw();
  endtask

  task automatic m_rbit(output logic b);
    logic b1;
    sda_m = 1'b1; hw(); scl_m = 1'b1;
    repeat (2) @(negedge clk); b1 = sda_bus;
    repeat (2) @(negedge clk); b = sda_bus;
    chk("R10 sda steady while scl high", {7'b0, b}, {7'b0, b1});
    scl_m = 1'b0; hw();
  endtask

  // request: push expected returned byte, run the transaction
  task automatic m_request(input logic [7:0] addr_byte, input logic exp_ack,
                           input logic [7:0] exp_byte, input logic [1:0] inj,
                           input string tag);
    logic ack, b;
    logic [7:0] got;
    if (!exp_ack) begin exp_q.push_back(exp_byte); tag_q.push_back(tag); end
    m_start();
    for (int i = 7; i >= 0; i--) m_wbit(addr_byte[i]);
    m_rbit(ack);
    chk({tag, " ack bit"}, {7'b0, ack}, {7'b0, exp_ack});
    if (!exp_ack && !ack) begin
      got = 8'h00;
      for (int i = 7; i >= 0; i--) begin
        m_rbit(b);
        got[i] = b;
        if (i == 4 && inj != 2'b00) begin
          fault0 = inj[0]; fault1 = inj[1];
          @(negedge clk);
          fault0 = 1'b0; fault1 = 1'b0;
        end
      end
      m_wbit(1'b1);
      rd_byte = got; rd_strobe = 1'b1;
      @(negedge clk); rd_strobe = 1'b0;
    end
    m_stop();
    hw();
  endtask

  // monitor: compare each returned byte with the queued expectation
  always @(posedge rd_strobe) begin
    logic [7:0] e;
    string t;
    if (exp_q.size() == 0) begin
      checks++; fails++;
      $display("FAIL R5 unexpected byte got %h expected none", rd_byte);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " returned byte"}, rd_byte, e);
    end
  end

  task automatic pulse(input logic f0, input logic f1);
    fault0 = f0; fault1 = f1; @(negedge clk); fault0 = 1'b0; fault1 = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 oe0", {7'b0, oe0}, 8'h00);
    chk("R1 oe1", {7'b0, oe1}, 8'h00);
    chk("R1 alert0", {7'b0, alert0}, 8'h00);
    chk("R1 alert1", {7'b0, alert1}, 8'h00);
    rst_n = 1'b1;
    hw();
    // R4 no pending fault: no acknowledge
    m_request(8'h19, 1'b1, 8'h00, 2'b00, "R4 idle request");
    chk("R4 alerts idle", {6'b0, alert1, alert0}, 8'h00);
    // R2 fault sets alert, R3 ack, R5 byte, R7 clear
    pulse(1'b0, 1'b1);
    chk("R2 alert1 set", {6'b0, alert1, alert0}, 8'h02);
    m_request(8'h19, 1'b0, 8'h99, 2'b00, "R3 R5 single responder");
    chk("R7 alert1 cleared", {6'b0, alert1, alert0}, 8'h00);
    // R11 R6 two responders, lower address wins
    pulse(1'b1, 1'b1);
    chk("R2 both alerts", {6'b0, alert1, alert0}, 8'h03);
    m_request(8'h19, 1'b0, 8'h55, 2'b00, "R11 arbitration winner");
    chk("R6 loser keeps alert", {6'b0, alert1, alert0}, 8'h02);
    m_request(8'h19, 1'b0, 8'h99, 2'b00, "R11 second request");
    chk("R11 loser served", {6'b0, alert1, alert0}, 8'h00);
    // R4 wrong first bytes
    pulse(1'b1, 1'b0);
    m_request(8'h18, 1'b1, 8'h00, 2'b00, "R4 write form");
    m_request(8'h39, 1'b1, 8'h00, 2'b00, "R4 other address");
    chk("R4 alert kept", {6'b0, alert1, alert0}, 8'h01);
    // R9 stop and repeated start mid-address
    m_start();
    for (int i = 0; i < 5; i++) m_wbit(1'b0);
    m_stop(); hw();
    chk("R9 stop keeps flag", {6'b0, alert1, alert0}, 8'h01);
    m_start();
    for (int i = 0; i < 3; i++) m_wbit(1'b0);
    m_request(8'h19, 1'b0, 8'h55, 2'b00, "R9 after repeated start");
    chk("R9 served after restart", {6'b0, alert1, alert0}, 8'h00);
    // R8 fault during the response
    pulse(1'b1, 1'b0);
    m_request(8'h19, 1'b0, 8'h55, 2'b01, "R8 fault mid byte");
    chk("R8 alert re-armed", {6'b0, alert1, alert0}, 8'h01);
    m_request(8'h19, 1'b0, 8'h55, 2'b00, "R7 final serve");
    chk("R7 alert0 cleared", {6'b0, alert1, alert0}, 8'h00);
    chk("R5 queue drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule